// File: doc/BRIEF.md
# Streaming Ungrouped Aggregator Stage

This stage sits in a chain of stream operators that process a table as a sequence of 128-bit chunks. Each tuple spans one or more chunks, and the final chunk of a tuple is marked. Earlier filter stages mark each tuple as accepted or rejected. The stage forwards every chunk unchanged, with no added latency. It also folds one 32-bit attribute of each accepted tuple into a single aggregate: a signed sum, a count, a signed minimum or a signed maximum.

A run-time position picks the attribute: a chunk number inside the tuple and a 32-bit word number inside that chunk. The end of the table is flagged on the last chunk of the last tuple. Once that chunk has been accepted, the stage injects one extra chunk at the tail of the stream that carries the 64-bit result. It then clears itself for the next table. In bypass mode the stream passes through untouched and no result chunk is produced.

Top module: `aggStreamStage`

## Requirements
- R1: While no result chunk is pending, outValid, outData, outLast and outPass equal inValid, inData, inLast and inPass in the same cycle, and inReady equals outReady.
- R2: cfgFunc selects the function: 0 is the signed 64-bit sum of the sign-extended attributes, 1 is the count of contributing tuples, 2 is the signed minimum and 3 is the signed maximum. Minimum and maximum are reported sign-extended to 64 bits.
- R3: The attribute is 32-bit word cfgWordIdx of chunk cfgChunkIdx of each tuple. Word k occupies bits 32k+31 down to 32k. Chunk 0 is the first chunk after a chunk with inLast=1, or the first chunk after reset or after a result.
- R4: A tuple contributes only when inPass is 1 on its last chunk. The value of inPass on the tuple's other chunks has no effect on the result.
- R5: When a chunk with inLast=1 and inEnd=1 is accepted in aggregate mode, the next output chunk is the result chunk. It carries the result in bits 63:0, zeros in bits 127:64, and outResult=1, outLast=1, outPass=1 and outEnd=1. inReady is 0 while the result chunk is pending.
- R6: In aggregate mode every forwarded input chunk leaves with outEnd=0 and outResult=0, so the end-of-table mark moves onto the result chunk.
- R7: While the result chunk is presented and outReady is 0, it stays valid with unchanged data.
- R8: A table with no contributing tuple reports 0 for sum and count, 64'h000000007FFFFFFF for minimum and 64'hFFFFFFFF80000000 for maximum.
- R9: After the result chunk is accepted, the aggregate and the chunk position restart, so the next table is folded independently of the previous one.
- R10: With cfgBypass=1 held for a whole table, the stream leaves unchanged, including outEnd, and no result chunk is emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgBypass | input | 1 | 1 passes the stream untouched and suppresses aggregation |
| cfgFunc | input | 2 | Aggregate function code (0 sum, 1 count, 2 min, 3 max) |
| cfgChunkIdx | input | 4 | Chunk number of the attribute inside a tuple |
| cfgWordIdx | input | 2 | 32-bit word number of the attribute inside that chunk |
| inValid | input | 1 | Upstream chunk valid |
| inReady | output | 1 | Stage accepts the upstream chunk |
| inData | input | 128 | Upstream chunk data |
| inLast | input | 1 | Chunk is the last of its tuple |
| inPass | input | 1 | Tuple accepted by earlier filters (read on the last chunk) |
| inEnd | input | 1 | Chunk ends the table (meaningful with inLast) |
| outValid | output | 1 | Downstream chunk valid |
| outReady | input | 1 | Downstream accepts the chunk |
| outData | output | 128 | Downstream chunk data |
| outLast | output | 1 | Downstream last-of-tuple mark |
| outPass | output | 1 | Downstream predicate mark |
| outEnd | output | 1 | Downstream end-of-table mark |
| outResult | output | 1 | Chunk is the appended aggregate result |

## Verification
The hardest case to reach is a result chunk that meets a stalled sink while the final tuple's attribute was captured several chunks earlier. The pass bit on that tuple's intermediate chunks must also disagree with the pass bit on its last chunk. The stimulus gives every non-final chunk a random pass bit drawn apart from the final one, toggles the sink's ready at random, and runs multi-chunk tuples with the attribute in an early chunk. Tables with every tuple rejected and tables run back to back without reset cover the empty-result and restart values.

// File: rtl/aggStreamPkg.sv
package aggStreamPkg;

  typedef enum logic [1:0] {
    FN_SUM   = 2'd0,
    FN_COUNT = 2'd1,
    FN_MIN   = 2'd2,
    FN_MAX   = 2'd3
  } aggFunc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic captureAttr;  // latch the attribute word of the current chunk
    logic commitTuple;  // fold the tuple's attribute into the aggregate
    logic clearAcc;     // result accepted: restart the aggregate
    logic appendOn;     // result chunk is being presented
  } aggStrobe_t;

endpackage

// File: rtl/aggCtrl.sv
module aggCtrl
  import aggStreamPkg::*;
#(
  parameter int CHUNK_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgBypass,
  input  logic [CHUNK_W-1:0] cfgChunkIdx,
  input  logic               inValid,
  input  logic               inLast,
  input  logic               inPass,
  input  logic               inEnd,
  input  logic               outReady,
  output logic               inReady,
  output aggStrobe_t         strobe
);

  logic [CHUNK_W-1:0] chunkCnt;
  logic gotAttr;
  logic appendQ;
  logic xfer;
  logic hit;
  logic haveAttr;

  always_comb begin
    inReady  = !appendQ && outReady;
    xfer     = inValid && inReady;
    hit      = xfer && !cfgBypass && (chunkCnt == cfgChunkIdx);
    haveAttr = gotAttr || hit;
    strobe.captureAttr = hit;
    strobe.commitTuple = xfer && inLast && inPass && !cfgBypass && haveAttr;
    strobe.clearAcc    = appendQ && outReady;
    strobe.appendOn    = appendQ;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chunkCnt <= '0;
      gotAttr  <= 1'b0;
      appendQ  <= 1'b0;
    end else begin
      if (xfer) begin
        if (inLast) begin
          chunkCnt <= '0;
          gotAttr  <= 1'b0;
        end else begin
          chunkCnt <= chunkCnt + 1'b1;
          gotAttr  <= haveAttr;
        end
      end
      if (xfer && inLast && inEnd && !cfgBypass) begin
        appendQ <= 1'b1;
      end else if (appendQ && outReady) begin
        appendQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/aggDatapath.sv
module aggDatapath
  import aggStreamPkg::*;
#(
  parameter int DATA_W = 128,
  parameter int ATTR_W = 32,
  parameter int ACC_W  = 64,
  localparam int WORDS  = DATA_W / ATTR_W,
  localparam int WSEL_W = $clog2(WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  aggStrobe_t        strobe,
  input  logic [1:0]        cfgFunc,
  input  logic [WSEL_W-1:0] cfgWordIdx,
  input  logic [DATA_W-1:0] inData,
  output logic [ACC_W-1:0]  result
);

  localparam int EXT_W = ACC_W - ATTR_W;

  logic [ATTR_W-1:0] words [WORDS];
  logic [ATTR_W-1:0] wordLive;
  logic [ATTR_W-1:0] attrQ;
  logic [ATTR_W-1:0] attrUse;
  logic [ACC_W-1:0]  attrExt;
  logic [ACC_W-1:0]  accQ;
  logic              emptyQ;
  logic [ACC_W-1:0]  initVal;
  logic [ACC_W-1:0]  base;
  logic [ACC_W-1:0]  folded;

  for (genvar g = 0; g < WORDS; g++) begin : gWord
    assign words[g] = inData[g*ATTR_W +: ATTR_W];
  end

  always_comb begin
    wordLive = words[cfgWordIdx];
    attrUse  = strobe.captureAttr ? wordLive : attrQ;
    attrExt  = {{EXT_W{attrUse[ATTR_W-1]}}, attrUse};
    case (aggFunc_e'(cfgFunc))
      FN_MIN:  initVal = {{(EXT_W+1){1'b0}}, {(ATTR_W-1){1'b1}}};
      FN_MAX:  initVal = {{(EXT_W+1){1'b1}}, {(ATTR_W-1){1'b0}}};
      default: initVal = '0;
    endcase
    base = emptyQ ? initVal : accQ;
    case (aggFunc_e'(cfgFunc))
      FN_SUM:   folded = base + attrExt;
      FN_COUNT: folded = base + 1'b1;
      FN_MIN:   folded = ($signed(attrExt) < $signed(base)) ? attrExt : base;
      FN_MAX:   folded = ($signed(attrExt) > $signed(base)) ? attrExt : base;
      default:  folded = base;
    endcase
    result = base;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      attrQ  <= '0;
      accQ   <= '0;
      emptyQ <= 1'b1;
    end else begin
      if (strobe.captureAttr) attrQ <= wordLive;
      if (strobe.clearAcc) begin
        accQ   <= '0;
        emptyQ <= 1'b1;
      end else if (strobe.commitTuple) begin
        accQ   <= folded;
        emptyQ <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/aggStreamStage.sv
module aggStreamStage
  import aggStreamPkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int ATTR_W  = 32,
  parameter int ACC_W   = 64,
  parameter int CHUNK_W = 4,
  localparam int WSEL_W = $clog2(DATA_W / ATTR_W)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgBypass,
  input  logic [1:0]         cfgFunc,
  input  logic [CHUNK_W-1:0] cfgChunkIdx,
  input  logic [WSEL_W-1:0]  cfgWordIdx,
  input  logic               inValid,
  output logic               inReady,
  input  logic [DATA_W-1:0]  inData,
  input  logic               inLast,
  input  logic               inPass,
  input  logic               inEnd,
  output logic               outValid,
  input  logic               outReady,
  output logic [DATA_W-1:0]  outData,
  output logic               outLast,
  output logic               outPass,
  output logic               outEnd,
  output logic               outResult
);

  aggStrobe_t       strobe;
  logic [ACC_W-1:0] result;

  aggCtrl #(.CHUNK_W(CHUNK_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cfgBypass(cfgBypass), .cfgChunkIdx(cfgChunkIdx),
    .inValid(inValid), .inLast(inLast), .inPass(inPass), .inEnd(inEnd),
    .outReady(outReady), .inReady(inReady), .strobe(strobe)
  );

  aggDatapath #(.DATA_W(DATA_W), .ATTR_W(ATTR_W), .ACC_W(ACC_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfgFunc(cfgFunc),
    .cfgWordIdx(cfgWordIdx), .inData(inData), .result(result)
  );

  always_comb begin
    if (strobe.appendOn) begin
      outValid  = 1'b1;
      outData   = {{(DATA_W-ACC_W){1'b0}}, result};
      outLast   = 1'b1;
      outPass   = 1'b1;
      outEnd    = 1'b1;
      outResult = 1'b1;
    end else begin
      outValid  = inValid;
      outData   = inData;
      outLast   = inLast;
      outPass   = inPass;
      outEnd    = inEnd && cfgBypass;
      outResult = 1'b0;
    end
  end

endmodule

// File: rtl/aggStreamStage_chk.sv
module aggStreamStage_chk #(
  parameter int DATA_W  = 128,
  parameter int CHUNK_W = 4,
  parameter int WSEL_W  = 2
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgBypass,
  input logic               inValid,
  input logic               inReady,
  input logic [DATA_W-1:0]  inData,
  input logic               inLast,
  input logic               inPass,
  input logic               outValid,
  input logic               outReady,
  input logic [DATA_W-1:0]  outData,
  input logic               outLast,
  input logic               outPass,
  input logic               outEnd,
  input logic               outResult
);

  // R1: zero-latency pass-through when no result is pending
  a_r1_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    !outResult |-> (outValid == inValid && outData == inData && outLast == inLast
                    && outPass == inPass && inReady == outReady));

  // R5: result chunk blocks upstream and carries its marks
  a_r5_result_fields: assert property (@(posedge clk) disable iff (!rstN)
    outResult |-> (!inReady && outValid && outLast && outEnd && outPass
                   && outData[DATA_W-1:64] == '0));

  // R6: forwarded chunks lose the end mark in aggregate mode
  a_r6_end_moved: assert property (@(posedge clk) disable iff (!rstN)
    (!outResult && !cfgBypass) |-> !outEnd);

  // R7: stalled result held stable
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    (outResult && !outReady) |=> (outResult && $stable(outData)));

  // R9: one result chunk per table
  a_r9_single_result: assert property (@(posedge clk) disable iff (!rstN)
    (outResult && outReady) |=> !outResult);

  // R10: bypass never starts a result chunk
  a_r10_bypass_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (cfgBypass && !outResult) |=> !outResult);

endmodule

bind aggStreamStage aggStreamStage_chk #(.DATA_W(DATA_W), .CHUNK_W(CHUNK_W), .WSEL_W(WSEL_W)) chk (
  .clk(clk), .rstN(rstN), .cfgBypass(cfgBypass), .inValid(inValid), .inReady(inReady),
  .inData(inData), .inLast(inLast), .inPass(inPass), .outValid(outValid),
  .outReady(outReady), .outData(outData), .outLast(outLast), .outPass(outPass),
  .outEnd(outEnd), .outResult(outResult)
);

// File: tb/aggStreamStage_test.sv
module aggStreamStage_test;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         cfgBypass = 1'b0;
  logic [1:0]   cfgFunc = 2'd0;
  logic [3:0]   cfgChunkIdx = 4'd0;
  logic [1:0]   cfgWordIdx = 2'd0;
  logic         inValid = 1'b0;
  logic         inReady;
  logic [127:0] inData = '0;
  logic         inLast = 1'b0;
  logic         inPass = 1'b0;
  logic         inEnd = 1'b0;
  logic         outValid;
  logic         outReady = 1'b0;
  logic [127:0] outData;
  logic         outLast, outPass, outEnd, outResult;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  logic [127:0] stData [64];
  logic         stPass [64];
  logic [127:0] obData [65];
  logic         obLast [65], obPass [65], obEnd [65], obRes [65];

  always #2 clk = ~clk;

  aggStreamStage uut (
    .clk(clk), .rstN(rstN), .cfgBypass(cfgBypass), .cfgFunc(cfgFunc),
    .cfgChunkIdx(cfgChunkIdx), .cfgWordIdx(cfgWordIdx), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inLast(inLast), .inPass(inPass),
    .inEnd(inEnd), .outValid(outValid), .outReady(outReady), .outData(outData),
    .outLast(outLast), .outPass(outPass), .outEnd(outEnd), .outResult(outResult)
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
        summary();
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pickWord();
    int r = $urandom % 8;
    if (r == 0) return 32'h8000_0000;
    if (r == 1) return 32'h7FFF_FFFF;
    return $urandom;
  endfunction

  // independent model of the aggregate (R2, R3, R4, R8)
  function automatic logic [63:0] model(int fn, int cidx, int widx, int cpt, int ntup);
    longint acc;
    longint v;
    case (fn)
      2: acc = 64'sh0000_0000_7FFF_FFFF;
      3: acc = -64'sh0000_0000_8000_0000;
      default: acc = 0;
    endcase
    for (int t = 0; t < ntup; t++) begin
      if (stPass[t*cpt + cpt - 1]) begin
        v = longint'($signed(stData[t*cpt + cidx][widx*32 +: 32]));
        case (fn)
          0: acc = acc + v;
          1: acc = acc + 1;
          2: if (v < acc) acc = v;
          default: if (v > acc) acc = v;
        endcase
      end
    end
    return acc;
  endfunction

  // passMode: 0 all rejected, 1 random, 2 all accepted
  task automatic runTable(int fn, int cidx, int widx, int cpt, int ntup,
                          bit byp, int passMode, bit randReady, string tag);
    int n = cpt * ntup;
    int expOut = byp ? n : n + 1;
    int si = 0;
    int oi = 0;
    int guard = 0;
    bit held = 1'b0;
    logic [127:0] heldData = '0;
    logic [63:0] expRes;
    int badPass = 0;
    for (int k = 0; k < n; k++) begin
      stData[k] = {pickWord(), pickWord(), pickWord(), pickWord()};
      if ((k % cpt) == cpt - 1)
        stPass[k] = (passMode == 2) ? 1'b1 : (passMode == 0) ? 1'b0 : 1'($urandom % 2);
      else
        stPass[k] = 1'($urandom % 2);
    end
    @(negedge clk);
    cfgFunc = 2'(fn); cfgChunkIdx = 4'(cidx); cfgWordIdx = 2'(widx); cfgBypass = byp;
    while (oi < expOut && guard < 4000) begin
      @(negedge clk);
      guard++;
      outReady = randReady ? 1'($urandom % 2) : 1'b1;
      if (si < n) begin
        inValid = 1'b1;
        inData  = stData[si];
        inPass  = stPass[si];
        inLast  = (si % cpt) == cpt - 1;
        inEnd   = (si == n - 1);
      end else begin
        inValid = 1'b0;
        inData = '0; inPass = 1'b0; inLast = 1'b0; inEnd = 1'b0;
      end
      #1;
      if (held) begin
        // R7: result stays while the sink stalls
        check(outValid && outResult && outData == heldData, {tag, " R7 held result"},
              outData, heldData);
      end
      held = outValid && outResult && !outReady;
      heldData = outData;
      if (outValid && outReady && oi < 65) begin
        obData[oi] = outData; obLast[oi] = outLast; obPass[oi] = outPass;
        obEnd[oi] = outEnd; obRes[oi] = outResult;
        oi++;
      end
      if (inValid && inReady) si++;
    end
    check(guard < 4000, {tag, " stream completed"}, 128'(oi), 128'(expOut));
    @(negedge clk);
    inValid = 1'b0; inData = '0; inLast = 1'b0; inPass = 1'b0; inEnd = 1'b0; outReady = 1'b1;
    #1;
    // R5/R10: nothing more than the expected chunks
    check(!outValid, {tag, " R10 R5 no extra chunk"}, 128'(outValid), 128'(0));
    for (int k = 0; k < n; k++) begin
      if (obData[k] != stData[k] || obPass[k] != stPass[k] ||
          obLast[k] != ((k % cpt) == cpt - 1) || obRes[k] != 1'b0 ||
          obEnd[k] != (byp && k == n - 1))
        badPass++;
    end
    check(badPass == 0, {tag, " R1 R6 R10 forwarded chunks"}, 128'(badPass), 128'(0));
    if (!byp) begin
      expRes = model(fn, cidx, widx, cpt, ntup);
      check(obData[n] == {64'd0, expRes}, {tag, " R2 R3 R4 R8 R9 result value"},
            obData[n], {64'd0, expRes});
      check(obRes[n] && obLast[n] && obPass[n] && obEnd[n], {tag, " R5 result marks"},
            {obRes[n], obLast[n], obPass[n], obEnd[n]}, 128'hF);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    outReady = 1'b1;
    #1;
    check(!outValid && !outResult && inReady, "reset state R1", 
          {outValid, outResult, inReady}, 128'b001);
    runTable(0, 1, 2, 3, 12, 1'b0, 1, 1'b1, "sum multi-chunk");
    runTable(1, 0, 0, 1, 20, 1'b0, 1, 1'b1, "count single-chunk");
    runTable(2, 2, 3, 4, 8,  1'b0, 1, 1'b1, "min late chunk");
    runTable(3, 0, 1, 2, 10, 1'b0, 2, 1'b1, "max all pass");
    runTable(2, 1, 0, 2, 5,  1'b0, 0, 1'b0, "min empty R8");
    runTable(3, 0, 3, 1, 4,  1'b0, 0, 1'b1, "max empty R8");
    runTable(0, 0, 2, 3, 3,  1'b0, 0, 1'b1, "sum empty R8");
    runTable(1, 0, 0, 2, 1,  1'b0, 2, 1'b0, "count one tuple");
    runTable(0, 1, 1, 2, 6,  1'b1, 1, 1'b1, "bypass R10");
    runTable(0, 1, 1, 2, 6,  1'b0, 1, 1'b1, "sum after bypass R9");
    for (int i = 0; i < 8; i++) begin
      int cpt = 1 + ($urandom % 4);
      runTable(int'($urandom % 4), int'($urandom % cpt), int'($urandom % 4), cpt,
               1 + int'($urandom % 12), ($urandom % 6) == 0, 1, 1'b1, "random R9");
    end
    summary();
  end

endmodule